// File: doc/BRIEF.md
# ATA Command Validation Front End

This block sits between a host task-file register set and the command engines of a storage controller. A command is offered for one cycle on `cmd_valid` with its opcode, feature byte, 16-bit sector count and 48-bit LBA. The block classifies the command, expands its sector count into a true transfer length, and counts the completion interrupts the host will see. It rejects commands the device does not implement, and it flags reads, writes and verifies that reach past the current address ceiling. Whether a command is a 28-bit or a 48-bit form is taken from its opcode.

The block keeps three pieces of device state that later commands depend on. The first is the SMART enable. The second is the settable maximum address, which starts at the native maximum. The third is the sector block size used by the multiple-sector PIO commands. Each command sees the state left by the commands before it. The result is registered and appears together with a one-cycle done strobe.

Top module: `ata_cmd_front`

## Requirements
- R1: Each result appears, with `res_done` high for exactly one cycle, in the cycle after the one in which `cmd_valid` was high; `res_done` is low at all other times.
- R2: 28-bit transfer opcodes (20h/21h, 30h/31h, 40h/41h, C4h, C5h, C8h–CBh) use the low 8 bits of the count, with 0 meaning 256 sectors, and only LBA bits 27:0 as the start address.
- R3: 48-bit transfer opcodes (24h, 25h, 29h, 34h, 35h, 39h, 42h) use the full 16-bit count, with 0 meaning 65536 sectors, and the full 48-bit start address.
- R4: `res_class` is 0 for non-data, 1 for PIO read, 2 for PIO write, 3 for DMA and 4 for the diagnostic (90h); verify commands (40h–42h), the power and cache commands (E0h, E1h, E5h, E6h, E7h, EAh) and the set commands are class 0, and IDENTIFY (ECh) is a 1-sector PIO read.
- R5: Opcode B0h selects a SMART subcommand through the feature byte: D0h and D5h are 1-sector PIO reads; D2h, D4h and DAh are non-data; D8h enables SMART; D9h disables it. While SMART is disabled, every subcommand except D8h is aborted, including D9h.
- R6: A NOP (00h), any opcode not listed in R2–R5 and R7–R10, and a SMART feature not listed in R5 each complete with `res_abort`=1, `res_class`=0, `res_len`=0 and `res_irqs`=1.
- R7: F9h sets the maximum address to LBA bits 27:0, and 37h sets it to the full 48-bit LBA. A value above the native maximum is aborted and leaves the stored maximum unchanged.
- R8: A transfer whose last sector (start + length − 1, computed without wrap) is above the stored maximum completes with `res_idnf`=1, `res_abort`=0, its decoded class, `res_len`=0 and `res_irqs`=1. A last sector equal to the maximum is accepted.
- R9: The multiple block size is 16 after reset. C6h replaces it with count bits 7:0 when that value is a nonzero power of two, and is aborted otherwise.
- R10: DOWNLOAD MICROCODE (92h) is a PIO write of LBA bits 7:0 × 256 + count bits 7:0 sectors (0 to 65535).
- R11: After reset, `res_done` is low, SMART is disabled, the maximum address equals the native maximum, and the block size is 16.
- R12: `res_irqs` equals ceil(len / block size) for the multiple opcodes (29h, 39h, C4h, C5h), and equals len for every other PIO command with a nonzero length. In all other cases it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_feat | input | 8 | Feature byte |
| cmd_count | input | 16 | Sector count field |
| cmd_lba | input | 48 | LBA field |
| res_done | output | 1 | Result valid strobe |
| res_class | output | 3 | Command class code |
| res_len | output | 17 | Normalized transfer length in sectors |
| res_irqs | output | 17 | Completion interrupts the command raises |
| res_abort | output | 1 | Command aborted |
| res_idnf | output | 1 | Address beyond the maximum |

## Verification
All five result fields and the done strobe come from a single register stage. They are therefore due exactly one clock edge after the cycle that carries `cmd_valid`. The bench drives each command on a falling edge, and it reads the outputs at the following falling edge, half a cycle after the capturing rising edge. A state change from SET MAX, SET MULTIPLE or a SMART enable is visible to the very next command, so the bench's reference model updates its state in the same call that predicts the result of the command that caused the change. Directed cases cover zero counts, a last sector equal to the maximum and one sector past it, and SMART gating. Random commands then drive the model and the design through many state histories.

// File: rtl/ata_fe_pkg.sv
package ata_fe_pkg;
  localparam int LBA_W  = 48;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = CNT_W + 1;
  localparam int BLK_W  = 8;
  localparam int LBA28  = 28;

  typedef enum logic [2:0] {
    CLS_ND   = 3'd0,
    CLS_PIN  = 3'd1,
    CLS_POUT = 3'd2,
    CLS_DMA  = 3'd3,
    CLS_DIAG = 3'd4
  } cls_e;

  typedef enum logic [2:0] {
    K_BAD, K_NOP, K_RW, K_FIXED, K_SMART, K_SETMULT, K_SETMAX, K_DLMC
  } kind_e;

  typedef struct packed {
    kind_e kind;
    cls_e  cls;
    logic  ext;
    logic  mult;
    logic  one_sec;
  } dec_t;

  // Expand the count field into a sector total
  function automatic logic [LEN_W-1:0] norm_len(input logic [CNT_W-1:0] cnt, input logic ext);
    if (ext) return (cnt == '0) ? LEN_W'(1) << CNT_W : {1'b0, cnt};
    return (cnt[7:0] == 8'd0) ? LEN_W'(256) : LEN_W'(cnt[7:0]);
  endfunction

  // Last addressed sector, one bit wider so it cannot wrap
  function automatic logic [LBA_W:0] last_lba(input logic [LBA_W-1:0] start, input logic [LEN_W-1:0] len);
    return {1'b0, start} + (LBA_W+1)'(len) - (LBA_W+1)'(1);
  endfunction

  // Block count rounded up; blk is a power of two
  function automatic logic [LEN_W-1:0] blocks(input logic [LEN_W-1:0] len, input logic [BLK_W-1:0] blk);
    logic [LEN_W:0] s;
    logic [LEN_W-1:0] r;
    s = {1'b0, len} + (LEN_W+1)'(blk) - (LEN_W+1)'(1);
    r = len;
    for (int i = 0; i < BLK_W; i++)
      if (blk[i]) r = LEN_W'(s >> i);
    return r;
  endfunction
endpackage

// File: rtl/ata_fe_decode.sv
module ata_fe_decode
  import ata_fe_pkg::*;
(
  input  logic [7:0] op,
  input  logic [7:0] feat,
  output dec_t       dec
);
  always_comb begin
    dec = '{kind: K_BAD, cls: CLS_ND, ext: 1'b0, mult: 1'b0, one_sec: 1'b0};
    case (op)
      8'h00:               dec.kind = K_NOP;
      8'h20, 8'h21:        begin dec.kind = K_RW; dec.cls = CLS_PIN; end
      8'h24:               begin dec.kind = K_RW; dec.cls = CLS_PIN; dec.ext = 1'b1; end
      8'h25:               begin dec.kind = K_RW; dec.cls = CLS_DMA; dec.ext = 1'b1; end
      8'h29:               begin dec.kind = K_RW; dec.cls = CLS_PIN; dec.ext = 1'b1; dec.mult = 1'b1; end
      8'h30, 8'h31:        begin dec.kind = K_RW; dec.cls = CLS_POUT; end
      8'h34:               begin dec.kind = K_RW; dec.cls = CLS_POUT; dec.ext = 1'b1; end
      8'h35:               begin dec.kind = K_RW; dec.cls = CLS_DMA; dec.ext = 1'b1; end
      8'h39:               begin dec.kind = K_RW; dec.cls = CLS_POUT; dec.ext = 1'b1; dec.mult = 1'b1; end
      8'h40, 8'h41:        dec.kind = K_RW;
      8'h42:               begin dec.kind = K_RW; dec.ext = 1'b1; end
      8'hC4:               begin dec.kind = K_RW; dec.cls = CLS_PIN; dec.mult = 1'b1; end
      8'hC5:               begin dec.kind = K_RW; dec.cls = CLS_POUT; dec.mult = 1'b1; end
      8'hC8, 8'hC9,
      8'hCA, 8'hCB:        begin dec.kind = K_RW; dec.cls = CLS_DMA; end
      8'hC6:               dec.kind = K_SETMULT;
      8'hF9:               dec.kind = K_SETMAX;
      8'h37:               begin dec.kind = K_SETMAX; dec.ext = 1'b1; end
      8'h92:               begin dec.kind = K_DLMC; dec.cls = CLS_POUT; end
      8'h90:               begin dec.kind = K_FIXED; dec.cls = CLS_DIAG; end
      8'hB0:               begin
                             dec.kind = K_SMART;
                             if (feat == 8'hD0 || feat == 8'hD5) begin
                               dec.cls = CLS_PIN; dec.one_sec = 1'b1;
                             end
                           end
      8'hE0, 8'hE1, 8'hE5,
      8'hE6, 8'hE7, 8'hEA: dec.kind = K_FIXED;
      8'hEC:               begin dec.kind = K_FIXED; dec.cls = CLS_PIN; dec.one_sec = 1'b1; end
      default:             dec.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/ata_fe_state.sv
module ata_fe_state
  import ata_fe_pkg::*;
#(
  parameter logic [LBA_W-1:0] NATIVE_MAX   = 48'd250069679,
  parameter int               MULT_DEFAULT = 16,
  parameter int               MULT_MAX     = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smart_set,
  input  logic             smart_clr,
  input  logic             max_wr,
  input  logic [LBA_W-1:0] max_val,
  input  logic             mult_wr,
  input  logic [BLK_W-1:0] mult_val,
  output logic             smart_en,
  output logic [LBA_W-1:0] max_lba,
  output logic [BLK_W-1:0] mult_blk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smart_en <= 1'b0;
      max_lba  <= NATIVE_MAX;
      mult_blk <= BLK_W'(MULT_DEFAULT);
    end else begin
      if (smart_set)      smart_en <= 1'b1;
      else if (smart_clr) smart_en <= 1'b0;
      if (max_wr)  max_lba  <= max_val;
      if (mult_wr) mult_blk <= mult_val;
    end
  end

  // R7
  max_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_lba <= NATIVE_MAX);
  // R9
  mult_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mult_blk) == 1) && (int'(mult_blk) <= MULT_MAX));
  // R5
  smart_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smart_en != $past(smart_en)) |-> $past(smart_set || smart_clr));
endmodule

// File: rtl/ata_cmd_front.sv
module ata_cmd_front
  import ata_fe_pkg::*;
#(
  parameter logic [47:0] NATIVE_MAX   = 48'd250069679,
  parameter int          MULT_DEFAULT = 16,
  parameter int          MULT_MAX     = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic [7:0]  cmd_feat,
  input  logic [15:0] cmd_count,
  input  logic [47:0] cmd_lba,
  output logic        res_done,
  output logic [2:0]  res_class,
  output logic [16:0] res_len,
  output logic [16:0] res_irqs,
  output logic        res_abort,
  output logic        res_idnf
);
  dec_t             dec;
  logic             smart_en;
  logic [LBA_W-1:0] max_lba;
  logic [BLK_W-1:0] mult_blk;

  // Named internal events
  logic [LBA_W-1:0] lba_eff;
  logic [LEN_W-1:0] rw_len;
  logic [LBA_W:0]   rw_last;
  logic             range_err;
  logic [LBA_W-1:0] new_max;
  logic             max_ok, mult_ok;
  logic             want_set, want_clr, want_max, want_mult;
  logic [2:0]       n_cls;
  logic [LEN_W-1:0] n_len, n_irq;
  logic             n_abort, n_idnf;

  ata_fe_decode u_dec (.op(cmd_op), .feat(cmd_feat), .dec(dec));

  ata_fe_state #(.NATIVE_MAX(NATIVE_MAX), .MULT_DEFAULT(MULT_DEFAULT), .MULT_MAX(MULT_MAX)) u_state (
    .clk(clk), .rst_n(rst_n),
    .smart_set(cmd_valid && want_set), .smart_clr(cmd_valid && want_clr),
    .max_wr(cmd_valid && want_max), .max_val(new_max),
    .mult_wr(cmd_valid && want_mult), .mult_val(cmd_count[BLK_W-1:0]),
    .smart_en(smart_en), .max_lba(max_lba), .mult_blk(mult_blk));

  assign lba_eff   = dec.ext ? cmd_lba : LBA_W'(cmd_lba[LBA28-1:0]);
  assign rw_len    = norm_len(cmd_count, dec.ext);
  assign rw_last   = last_lba(lba_eff, rw_len);
  assign range_err = rw_last > {1'b0, max_lba};
  assign new_max   = lba_eff;
  assign max_ok    = new_max <= NATIVE_MAX;
  assign mult_ok   = ($countones(cmd_count[BLK_W-1:0]) == 1) && (int'(cmd_count[BLK_W-1:0]) <= MULT_MAX);

  always_comb begin
    n_cls = dec.cls; n_len = '0; n_abort = 1'b0; n_idnf = 1'b0;
    want_set = 1'b0; want_clr = 1'b0; want_max = 1'b0; want_mult = 1'b0;
    case (dec.kind)
      K_RW:      if (range_err) n_idnf = 1'b1; else n_len = rw_len;
      K_FIXED:   n_len = dec.one_sec ? LEN_W'(1) : '0;
      K_DLMC:    n_len = LEN_W'({cmd_lba[7:0], cmd_count[7:0]});
      K_SETMULT: if (mult_ok) want_mult = 1'b1; else n_abort = 1'b1;
      K_SETMAX:  if (max_ok) want_max = 1'b1; else n_abort = 1'b1;
      K_SMART: begin
        if (!smart_en && cmd_feat != 8'hD8) n_abort = 1'b1;
        else begin
          case (cmd_feat)
            8'hD0, 8'hD5: n_len = LEN_W'(1);
            8'hD2, 8'hD4, 8'hDA: ;
            8'hD8: want_set = 1'b1;
            8'hD9: want_clr = 1'b1;
            default: n_abort = 1'b1;
          endcase
        end
      end
      default: n_abort = 1'b1;
    endcase
    if (n_abort) n_cls = CLS_ND;
    if ((n_cls == CLS_PIN || n_cls == CLS_POUT) && n_len != '0)
      n_irq = dec.mult ? blocks(n_len, mult_blk) : n_len;
    else
      n_irq = LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done <= 1'b0; res_class <= '0; res_len <= '0;
      res_irqs <= '0; res_abort <= 1'b0; res_idnf <= 1'b0;
    end else begin
      res_done <= cmd_valid;
      if (cmd_valid) begin
        res_class <= n_cls; res_len <= n_len; res_irqs <= n_irq;
        res_abort <= n_abort; res_idnf <= n_idnf;
      end
    end
  end

  // R1
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(cmd_valid));
  // R8
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !(res_abort && res_idnf));
  // R6
  abort_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_abort) |-> (res_len == '0 && res_class == 3'd0 && res_irqs == 17'd1));
  // R8
  idnf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_idnf) |-> (res_len == '0 && res_irqs == 17'd1));
  // R5
  smart_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'hB0 && !smart_en && cmd_feat != 8'hD8) |=> res_abort);
endmodule

// File: tb/tb_ata_cmd_front.sv
`timescale 1ns/1ps
module tb_ata_cmd_front;
  localparam logic [47:0] NATIVE = 48'd250069679;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0, cmd_feat = '0;
  logic [15:0] cmd_count = '0;
  logic [47:0] cmd_lba = '0;
  logic        res_done, res_abort, res_idnf;
  logic [2:0]  res_class;
  logic [16:0] res_len, res_irqs;

  int errors = 0, checks = 0;
  bit    m_smart;
  longint m_max;
  int    m_mult;

  always #2.5 clk = ~clk;

  ata_cmd_front dut (.*);

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  task automatic model(input logic [7:0] op, input logic [7:0] f, input logic [15:0] c, input logic [47:0] l,
                       output int ecls, output int elen, output int eirq, output bit eab, output bit eid);
    bit rw, ext, mult;
    longint start, last, nm;
    rw = 0; ext = 0; mult = 0; ecls = 0; elen = 0; eab = 0; eid = 0;
    case (op)
      8'h20, 8'h21: begin rw = 1; ecls = 1; end
      8'h24: begin rw = 1; ecls = 1; ext = 1; end
      8'h25: begin rw = 1; ecls = 3; ext = 1; end
      8'h29: begin rw = 1; ecls = 1; ext = 1; mult = 1; end
      8'h30, 8'h31: begin rw = 1; ecls = 2; end
      8'h34: begin rw = 1; ecls = 2; ext = 1; end
      8'h35: begin rw = 1; ecls = 3; ext = 1; end
      8'h39: begin rw = 1; ecls = 2; ext = 1; mult = 1; end
      8'h40, 8'h41: rw = 1;
      8'h42: begin rw = 1; ext = 1; end
      8'hC4: begin rw = 1; ecls = 1; mult = 1; end
      8'hC5: begin rw = 1; ecls = 2; mult = 1; end
      8'hC8, 8'hC9, 8'hCA, 8'hCB: begin rw = 1; ecls = 3; end
      8'hC6: if ($countones(c[7:0]) == 1) m_mult = int'(c[7:0]); else eab = 1;
      8'hF9, 8'h37: begin
        nm = (op == 8'h37) ? longint'(l) : longint'(l[27:0]);
        if (nm > longint'(NATIVE)) eab = 1; else m_max = nm;
      end
      8'h92: begin ecls = 2; elen = int'(l[7:0]) * 256 + int'(c[7:0]); end
      8'h90: ecls = 4;
      8'hEC: begin ecls = 1; elen = 1; end
      8'hE0, 8'hE1, 8'hE5, 8'hE6, 8'hE7, 8'hEA: ;
      8'hB0: begin
        if (!m_smart && f != 8'hD8) eab = 1;
        else case (f)
          8'hD0, 8'hD5: begin ecls = 1; elen = 1; end
          8'hD2, 8'hD4, 8'hDA: ;
          8'hD8: m_smart = 1;
          8'hD9: m_smart = 0;
          default: eab = 1;
        endcase
      end
      default: eab = 1;
    endcase
    if (rw) begin
      if (ext) elen = (c == 0) ? 65536 : int'(c);
      else     elen = (c[7:0] == 0) ? 256 : int'(c[7:0]);
      start = ext ? longint'(l) : longint'(l[27:0]);
      last  = start + longint'(elen) - 1;
      if (last > m_max) begin eid = 1; elen = 0; end
    end
    if (eab) begin ecls = 0; elen = 0; end
    if ((ecls == 1 || ecls == 2) && elen > 0)
      eirq = mult ? (elen + m_mult - 1) / m_mult : elen;
    else
      eirq = 1;
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] f, input logic [15:0] c, input logic [47:0] l, input string req);
    int ecls, elen, eirq; bit eab, eid; bit ok;
    model(op, f, c, l, ecls, elen, eirq, eab, eid);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_feat = f; cmd_count = c; cmd_lba = l;
    @(negedge clk);
    cmd_valid = 1'b0;
    ok = res_done && int'(res_class) == ecls && int'(res_len) == elen && int'(res_irqs) == eirq
         && res_abort == eab && res_idnf == eid;
    if (!ok)
      $display("  op=%h feat=%h cnt=%h lba=%h got cls=%0d len=%0d irq=%0d ab=%0b id=%0b",
               op, f, c, l, res_class, res_len, res_irqs, res_abort, res_idnf);
    check(ok, req, "result {done,cls,len,irq,ab,id}",
          {res_done, 1'b0, res_class, res_len, res_irqs, res_abort, res_idnf},
          {1'b1, 4'(ecls), 17'(elen), 17'(eirq), eab, eid});
    @(negedge clk);
    check(!res_done, "R1", "done after one cycle", res_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] ops [0:31] = '{8'h00, 8'h20, 8'h21, 8'h24, 8'h25, 8'h29, 8'h30, 8'h31, 8'h34, 8'h35, 8'h39,
                               8'h40, 8'h41, 8'h42, 8'hC4, 8'hC5, 8'hC8, 8'hCA, 8'hC6, 8'hF9, 8'h37, 8'h92,
                               8'h90, 8'hB0, 8'hB0, 8'hB0, 8'hE7, 8'hEC, 8'h5A, 8'hFF, 8'hE1, 8'hC9};
    logic [7:0] feats [0:7] = '{8'hD0, 8'hD2, 8'hD4, 8'hD5, 8'hD8, 8'hD9, 8'hDA, 8'h11};
    void'($urandom(32'h5EED1));
    m_smart = 0; m_max = longint'(NATIVE); m_mult = 16;
    repeat (3) @(negedge clk);
    check(!res_done && !res_abort && !res_idnf, "R11", "outputs in reset", res_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_done, "R11", "done idle after reset", res_done, 0);

    // Reset state seen through commands (R11)
    issue(8'hC4, 8'h00, 16'd32, 48'd0, "R11");             // default block 16 -> 2 irqs
    issue(8'h20, 8'h00, 16'd1, NATIVE, "R11");             // last == native max
    issue(8'hB0, 8'hD0, 16'd0, 48'd0, "R5");               // SMART off -> abort
    issue(8'hB0, 8'hD9, 16'd0, 48'd0, "R5");               // disable while off -> abort
    // Count expansion
    issue(8'h20, 8'h00, 16'hFF00, 48'hFFFF_F000_0000, "R2"); // zero low byte -> 256, upper LBA ignored
    issue(8'h24, 8'h00, 16'h0000, 48'd100, "R3");          // zero -> 65536
    issue(8'h25, 8'h00, 16'hFFFF, 48'd0, "R3");
    issue(8'hC8, 8'h00, 16'd7, 48'd9, "R4");
    issue(8'h90, 8'h00, 16'd0, 48'd0, "R4");
    issue(8'hEC, 8'h00, 16'd0, 48'd0, "R4");
    issue(8'h42, 8'h00, 16'd5, 48'd1, "R4");
    // Abort paths
    issue(8'h00, 8'h00, 16'd3, 48'd0, "R6");
    issue(8'h77, 8'h00, 16'd3, 48'd0, "R6");
    // SMART
    issue(8'hB0, 8'hD8, 16'd0, 48'd0, "R5");
    issue(8'hB0, 8'hD0, 16'd0, 48'd0, "R5");
    issue(8'hB0, 8'hDA, 16'd0, 48'd0, "R5");
    issue(8'hB0, 8'h33, 16'd0, 48'd0, "R6");
    issue(8'hB0, 8'hD9, 16'd0, 48'd0, "R5");
    issue(8'hB0, 8'hD5, 16'd0, 48'd0, "R5");
    // Max address
    issue(8'hF9, 8'h00, 16'd0, 48'hABC0_0000_1000, "R7"); // uses low 28 bits -> 0x1000
    issue(8'h20, 8'h00, 16'd16, 48'hFF1, "R8");            // last = 0x1000 ok
    issue(8'h20, 8'h00, 16'd17, 48'hFF1, "R8");            // last = 0x1001 -> IDNF
    issue(8'h37, 8'h00, 16'd0, NATIVE + 48'd1, "R7");      // above native -> abort
    issue(8'h24, 8'h00, 16'd1, 48'd4097, "R8");
    issue(8'h37, 8'h00, 16'd0, 48'hFFFF_FFFF_FFF0, "R7");
    issue(8'h24, 8'h00, 16'd0, 48'hFFFF_FFFF_FFF0, "R8");  // no wrap -> IDNF
    issue(8'h37, 8'h00, 16'd0, NATIVE, "R7");
    // Multiple mode
    issue(8'hC6, 8'h00, 16'd4, 48'd0, "R9");
    issue(8'hC5, 8'h00, 16'd10, 48'd0, "R12");              // ceil(10/4)=3
    issue(8'hC6, 8'h00, 16'd6, 48'd0, "R9");                // not pow2 -> abort
    issue(8'hC6, 8'h00, 16'd0, 48'd0, "R9");
    issue(8'h29, 8'h00, 16'd0, 48'd0, "R12");               // 65536/4
    issue(8'h30, 8'h00, 16'd9, 48'd0, "R12");               // 9 irqs
    issue(8'h92, 8'h00, 16'h00FF, 48'hFF, "R10");           // 65535
    issue(8'h92, 8'h00, 16'h0000, 48'h00, "R10");           // 0 sectors

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      logic [7:0] op, f; logic [15:0] c; logic [47:0] l;
      op = ops[$urandom_range(0, 31)];
      f  = feats[$urandom_range(0, 7)];
      case ($urandom_range(0, 3))
        0: c = 16'd0;
        1: c = 16'($urandom_range(1, 40));
        default: c = 16'($urandom);
      endcase
      if (op == 8'hC6) c = 16'(1 << $urandom_range(0, 8));
      if ($urandom_range(0, 1) == 1) l = 48'($urandom_range(0, 5000));
      else l = 48'(m_max) - 48'($urandom_range(0, 300));
      if ((op == 8'hF9 || op == 8'h37) && $urandom_range(0, 2) == 0) l = NATIVE;
      issue(op, f, c, l, "R12");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule